// File: doc/BRIEF.md
# Paired-Unit Operand and Result Crossbar Row

This block is a row of crossbar slices that sit between a register file and a line of execution units. Each slice serves one pair of units, a left one and a right one. On the way in, one operand register per slice takes either the register-file read word or the word now on the result bus; the second choice is the bypass. It then feeds that single registered operand to both units of the pair. On the way out, the slice picks the left or the right unit's result and registers it. A chain multiplexer after that register either puts the local value on the result bus or passes along what arrives from the slice further down the chain. The end of the chain, slice 0, is the result bus itself, and that bus also loops back as the bypass source.

Narrow scalar operations are zero-extended once, at operand read. A size code keeps the low byte always, the second byte for 16 bits and wider, bits 31:16 for 32 bits and wider, and bits 63:32 only for 64 bits or SIMD. Most units return zero upper bits when given zero upper bits, so their results pass through unmasked. Operations that break this (bitwise NOT, negation) are flagged, and their result has the same size mask applied before the result register.

Top module: `xbar_row`

## Requirements
- R1: While reset is asserted, every slice's operand output and the result bus are all zero.
- R2: A slice's operand output in cycle t+1 is taken from its register-file word in cycle t when its bypass select is 0, and from the result bus in cycle t when the select is 1. One operand port serves both units of the pair.
- R3: The operand is masked by the size code (0 = 8 bits, 1 = 16, 2 = 32, 3 = 64). Bits at and above the operand size are zero. With the SIMD flag set, all 64 bits are kept whatever the size code.
- R4: The result register takes the right unit's result when the pick-right input is 1 and the left unit's result when it is 0.
- R5: A result presented in cycle t shows on the result bus in cycle t+1 when its slice owns the bus in that cycle. The latency is one cycle for every slice position.
- R6: When the not-zero-preserving flag is 1 and SIMD is 0, result bits at and above the result size code's width are cleared. When the flag is 0, or SIMD is 1, the result passes unmasked even for a narrow size code.
- R7: The result bus shows only the registered value of the slice whose bit is set in the one-hot owner vector. Non-owning slices have no effect on it, and with no owner bit set the bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rfData | input | NUM_SLICES*DATA_W | Register-file read word per slice |
| srcBypass | input | NUM_SLICES | Operand source per slice: 1 = result bus, 0 = register file |
| opSize | input | 2*NUM_SLICES | Operand size code per slice |
| opSimd | input | NUM_SLICES | Operand SIMD flag per slice (keeps all bits) |
| operand | output | NUM_SLICES*DATA_W | Registered operand per slice, shared by its left and right units |
| leftRes | input | NUM_SLICES*DATA_W | Left unit result per slice |
| rightRes | input | NUM_SLICES*DATA_W | Right unit result per slice |
| pickRight | input | NUM_SLICES | Result select per slice: 1 = right unit |
| resSize | input | 2*NUM_SLICES | Result size code per slice |
| resSimd | input | NUM_SLICES | Result SIMD flag per slice |
| resNotZeroSafe | input | NUM_SLICES | Result comes from an operation that does not keep upper zeros |
| busOwner | input | NUM_SLICES | One-hot: which slice drives the result bus this cycle |
| busOut | output | DATA_W | Result bus at the chain end |

## Verification
Directed all-ones words run through each size code, with and without SIMD. This separates the four lane boundaries, and a mask error at any lane edge shows up. All-ones results are sent with the not-zero-preserving flag both set and clear, which tells a mask applied to every result apart from one applied only to flagged results. A two-step case places a value on the bus from slice 3 and bypasses it into slice 1, which checks the loop from chain end back to operand. Random words, owners, sizes and selects then check the one-cycle result latency at every chain position against a bench model.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_B8  = 2'd0,
    SZ_B16 = 2'd1,
    SZ_B32 = 2'd2,
    SZ_B64 = 2'd3
  } chunkSize_e;

  // Strobes from slice control to slice datapath.
  typedef struct packed {
    logic [LANES-1:0] opKeep;     // lane enables for the operand mask
    logic [LANES-1:0] resKeep;    // lane enables for the result mask
    logic             takeBypass; // operand comes from the result bus
    logic             pickRight;  // result register takes the right unit
    logic             driveLocal; // chain mux puts the local result on the bus
  } sliceStrobes_t;

  // Lanes: 0 = [7:0], 1 = [15:8], 2 = [31:16], 3 = [top:32]
  function automatic logic [LANES-1:0] laneKeep(input logic [1:0] size, input logic simd);
    logic [LANES-1:0] keep;
    keep[0] = 1'b1;
    keep[1] = simd || (size != SZ_B8);
    keep[2] = simd || (size == SZ_B32) || (size == SZ_B64);
    keep[3] = simd || (size == SZ_B64);
    return keep;
  endfunction

endpackage

// File: rtl/xbar_slice_ctrl.sv
module xbar_slice_ctrl
  import xbar_pkg::*;
(
  input  logic          srcBypass,
  input  logic [1:0]    opSize,
  input  logic          opSimd,
  input  logic          pickRight,
  input  logic [1:0]    resSize,
  input  logic          resSimd,
  input  logic          resNotZeroSafe,
  input  logic          ownBus,
  output sliceStrobes_t strobe
);

  logic [LANES-1:0] resLanes;

  always_comb begin
    // Results from zero-preserving operations keep every lane; the
    // zero-extension was already applied to their operands.
    if (resNotZeroSafe) resLanes = laneKeep(resSize, resSimd);
    else                resLanes = '1;
  end

  always_comb begin
    strobe.opKeep     = laneKeep(opSize, opSimd);
    strobe.resKeep    = resLanes;
    strobe.takeBypass = srcBypass;
    strobe.pickRight  = pickRight;
    strobe.driveLocal = ownBus;
  end

endmodule

// File: rtl/xbar_slice_dp.sv
module xbar_slice_dp
  import xbar_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  sliceStrobes_t     strobe,
  input  logic [DATA_W-1:0] rfData,
  input  logic [DATA_W-1:0] busData,
  input  logic [DATA_W-1:0] leftRes,
  input  logic [DATA_W-1:0] rightRes,
  input  logic [DATA_W-1:0] chainIn,
  output logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] chainOut
);

  localparam int LANE1_LO = 8;
  localparam int LANE2_LO = 16;
  localparam int LANE3_LO = 32;

  function automatic logic [DATA_W-1:0] expandLanes(input logic [LANES-1:0] keep);
    logic [DATA_W-1:0] bits;
    for (int b = 0; b < DATA_W; b++) begin
      if (b < LANE1_LO)      bits[b] = keep[0];
      else if (b < LANE2_LO) bits[b] = keep[1];
      else if (b < LANE3_LO) bits[b] = keep[2];
      else                   bits[b] = keep[3];
    end
    return bits;
  endfunction

  logic [DATA_W-1:0] opSource, opNext, operandQ;
  logic [DATA_W-1:0] resPicked, resNext, resultQ;

  // Input side: bypass mux and zero-extension at read.
  always_comb begin
    opSource = strobe.takeBypass ? busData : rfData;
    opNext   = opSource & expandLanes(strobe.opKeep);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) operandQ <= '0;
    else       operandQ <= opNext;
  end

  // Output side: left/right pick and optional clear for flagged operations.
  always_comb begin
    resPicked = strobe.pickRight ? rightRes : leftRes;
    resNext   = resPicked & expandLanes(strobe.resKeep);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultQ <= '0;
    else       resultQ <= resNext;
  end

  assign operand  = operandQ;
  assign chainOut = strobe.driveLocal ? resultQ : chainIn;

endmodule

// File: rtl/xbar_row.sv
module xbar_row
  import xbar_pkg::*;
#(
  parameter int NUM_SLICES = 4,
  parameter int DATA_W     = 64
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_SLICES*DATA_W-1:0]   rfData,
  input  logic [NUM_SLICES-1:0]          srcBypass,
  input  logic [2*NUM_SLICES-1:0]        opSize,
  input  logic [NUM_SLICES-1:0]          opSimd,
  output logic [NUM_SLICES*DATA_W-1:0]   operand,
  input  logic [NUM_SLICES*DATA_W-1:0]   leftRes,
  input  logic [NUM_SLICES*DATA_W-1:0]   rightRes,
  input  logic [NUM_SLICES-1:0]          pickRight,
  input  logic [2*NUM_SLICES-1:0]        resSize,
  input  logic [NUM_SLICES-1:0]          resSimd,
  input  logic [NUM_SLICES-1:0]          resNotZeroSafe,
  input  logic [NUM_SLICES-1:0]          busOwner,
  output logic [DATA_W-1:0]              busOut
);

  localparam int CHAIN_LEN = NUM_SLICES + 1;

  logic [DATA_W-1:0] chainLink [CHAIN_LEN];

  assign chainLink[NUM_SLICES] = '0;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    sliceStrobes_t strobe;

    xbar_slice_ctrl u_ctrl (
      .srcBypass      (srcBypass[s]),
      .opSize         (opSize[2*s +: 2]),
      .opSimd         (opSimd[s]),
      .pickRight      (pickRight[s]),
      .resSize        (resSize[2*s +: 2]),
      .resSimd        (resSimd[s]),
      .resNotZeroSafe (resNotZeroSafe[s]),
      .ownBus         (busOwner[s]),
      .strobe         (strobe)
    );

    xbar_slice_dp #(.DATA_W(DATA_W)) u_dp (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobe),
      .rfData   (rfData[s*DATA_W +: DATA_W]),
      .busData  (busOut),
      .leftRes  (leftRes[s*DATA_W +: DATA_W]),
      .rightRes (rightRes[s*DATA_W +: DATA_W]),
      .chainIn  (chainLink[s+1]),
      .operand  (operand[s*DATA_W +: DATA_W]),
      .chainOut (chainLink[s])
    );
  end

  assign busOut = chainLink[0];

endmodule

// File: rtl/xbar_row_checker.sv
module xbar_row_checker #(
  parameter int NUM_SLICES = 4,
  parameter int DATA_W     = 64
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  srcBypass0,
  input logic [1:0]            opSize0,
  input logic                  opSimd0,
  input logic [DATA_W-1:0]     operand0,
  input logic [DATA_W-1:0]     leftRes0,
  input logic                  pickRight0,
  input logic [1:0]            resSize0,
  input logic                  resSimd0,
  input logic                  resNotZeroSafe0,
  input logic [NUM_SLICES-1:0] busOwner,
  input logic [DATA_W-1:0]     busOut
);

  a_r3_byte_operand_clear: assert property (@(posedge clk) disable iff (!rstN)
    (opSize0 == 2'd0 && !opSimd0) |=> (operand0[DATA_W-1:8] == '0));

  a_r2_full_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (srcBypass0 && (opSimd0 || opSize0 == 2'd3)) |=> (operand0 == $past(busOut)));

  a_r5_left_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (!pickRight0 && !resNotZeroSafe0) |=> (busOwner[0] -> (busOut == $past(leftRes0))));

  a_r6_flagged_byte_clear: assert property (@(posedge clk) disable iff (!rstN)
    (resNotZeroSafe0 && !resSimd0 && resSize0 == 2'd0) |=>
      (busOwner[0] -> (busOut[DATA_W-1:8] == '0)));

  a_r7_single_owner: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busOwner));

  a_r7_idle_bus_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busOwner == '0) |-> (busOut == '0));

endmodule

bind xbar_row xbar_row_checker #(.NUM_SLICES(NUM_SLICES), .DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .srcBypass0      (srcBypass[0]),
  .opSize0         (opSize[1:0]),
  .opSimd0         (opSimd[0]),
  .operand0        (operand[DATA_W-1:0]),
  .leftRes0        (leftRes[DATA_W-1:0]),
  .pickRight0      (pickRight[0]),
  .resSize0        (resSize[1:0]),
  .resSimd0        (resSimd[0]),
  .resNotZeroSafe0 (resNotZeroSafe[0]),
  .busOwner        (busOwner),
  .busOut          (busOut)
);

// File: tb/sim_xbar_row.sv
module sim_xbar_row;

  localparam int NS = 4;
  localparam int W  = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] rf [NS];
  logic [W-1:0] lRes [NS];
  logic [W-1:0] rRes [NS];
  logic [1:0]   oSz [NS];
  logic [1:0]   rSz [NS];
  logic [NS-1:0] byp, oSimd, pRight, rSimd, nzs, owner;

  logic [NS*W-1:0] rfFlat, lFlat, rFlat, opFlat;
  logic [2*NS-1:0] oSzFlat, rSzFlat;
  logic [W-1:0]    busOut;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      rfFlat[i*W +: W]  = rf[i];
      lFlat[i*W +: W]   = lRes[i];
      rFlat[i*W +: W]   = rRes[i];
      oSzFlat[2*i +: 2] = oSz[i];
      rSzFlat[2*i +: 2] = rSz[i];
    end
  end

  xbar_row #(.NUM_SLICES(NS), .DATA_W(W)) u0 (
    .clk(clk), .rstN(rstN), .rfData(rfFlat), .srcBypass(byp), .opSize(oSzFlat),
    .opSimd(oSimd), .operand(opFlat), .leftRes(lFlat), .rightRes(rFlat),
    .pickRight(pRight), .resSize(rSzFlat), .resSimd(rSimd),
    .resNotZeroSafe(nzs), .busOwner(owner), .busOut(busOut)
  );

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  logic [W-1:0] expOp [NS];
  logic [W-1:0] expRes [NS];

  function automatic logic [W-1:0] sizeMask(input logic [1:0] sz, input logic simd);
    if (simd) return '1;
    case (sz)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic logic [W-1:0] expBus();
    logic [W-1:0] v = '0;
    for (int i = NS - 1; i >= 0; i--) if (owner[i]) v = expRes[i];
    return v;
  endfunction

  task automatic check(input string tag, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Called after inputs are driven at a negedge: check, update model, advance.
  task automatic step(input string opTag, input string busTag);
    logic [W-1:0] b;
    #1;
    b = expBus();
    check(busTag, "bus", busOut, b);
    for (int i = 0; i < NS; i++) check(opTag, $sformatf("operand%0d", i), opFlat[i*W +: W], expOp[i]);
    if (rstN) begin
      for (int i = 0; i < NS; i++) begin
        expOp[i]  = (byp[i] ? b : rf[i]) & sizeMask(oSz[i], oSimd[i]);
        expRes[i] = (pRight[i] ? rRes[i] : lRes[i]) &
                    (nzs[i] ? sizeMask(rSz[i], rSimd[i]) : {W{1'b1}});
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    for (int i = 0; i < NS; i++) begin
      rf[i] = '0; lRes[i] = '0; rRes[i] = '0; oSz[i] = 2'd3; rSz[i] = 2'd3;
    end
    byp = '0; oSimd = '0; pRight = '0; rSimd = '0; nzs = '0; owner = '0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NS; i++) begin expOp[i] = '0; expRes[i] = '0; end
    quiet();
    for (int i = 0; i < NS; i++) begin rf[i] = '1; lRes[i] = '1; end
    owner = 4'b0100;
    @(negedge clk);
    // R1: reset holds operand and bus at zero despite active inputs.
    step("R1", "R1");
    step("R1", "R1");
    rstN = 1'b1;
    quiet();

    // R3: operand zero-extension per size code, then SIMD keeps all bits.
    for (int sz = 0; sz < 4; sz++) begin
      for (int i = 0; i < NS; i++) begin rf[i] = '1; oSz[i] = 2'(sz); end
      step("R3", "R3");
    end
    oSz[0] = 2'd0; oSimd = 4'b0001;
    step("R3", "R3");
    oSimd = '0;
    step("R3", "R3");

    // R4: left vs right result selection, owned by slice 0 next cycle.
    lRes[0] = 64'h1111_2222_3333_4444; rRes[0] = 64'hAAAA_BBBB_CCCC_DDDD;
    pRight = 4'b0001;
    step("R4", "R4");
    owner = 4'b0001; pRight = '0;
    step("R4", "R4");
    owner = 4'b0001;
    step("R4", "R4");

    // R6: flagged narrow result is cleared; unflagged or SIMD passes whole.
    quiet();
    lRes[0] = '1; rSz[0] = 2'd0; nzs = 4'b0001;
    step("R6", "R6");
    owner = 4'b0001; nzs = '0;
    step("R6", "R6");
    rSimd = 4'b0001; nzs = 4'b0001;
    step("R6", "R6");
    rSimd = '0; nzs = 4'b0001; rSz[0] = 2'd1;
    step("R6", "R6");
    step("R6", "R6");

    // R7: different values per slice, rotate the owner, then no owner.
    quiet();
    for (int i = 0; i < NS; i++) lRes[i] = {16{4'(i + 5)}};
    step("R7", "R7");
    for (int i = 0; i < NS; i++) begin owner = 4'(1 << i); step("R7", "R7"); end
    owner = '0;
    step("R7", "R7");

    // R2: value from slice 3 goes on the bus and is bypassed into slice 1.
    quiet();
    lRes[3] = 64'hFEDC_BA98_7654_3210; rf[1] = 64'h0123;
    step("R2", "R2");
    owner = 4'b1000; byp = 4'b0010;
    step("R2", "R2");
    byp = '0;
    step("R2", "R2");

    // R5: random traffic, one-cycle latency at every chain position.
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < NS; i++) begin
        rf[i]   = {$urandom, $urandom};
        lRes[i] = {$urandom, $urandom};
        rRes[i] = {$urandom, $urandom};
        oSz[i]  = 2'($urandom % 4);
        rSz[i]  = 2'($urandom % 4);
      end
      byp    = 4'($urandom);
      oSimd  = 4'($urandom) & 4'($urandom);
      pRight = 4'($urandom);
      rSimd  = 4'($urandom) & 4'($urandom);
      nzs    = 4'($urandom);
      owner  = ($urandom % 8 == 0) ? 4'b0000 : 4'(1 << ($urandom % NS));
      step("R5", "R5");
    end

    finishRun();
  end

endmodule